// File: doc/BRIEF.md
# Clocked XOR Boolean Network Core

This block is a synchronous, fully deterministic model of a recurrent Boolean network. It has `N` one-bit nodes. Each node reads three other nodes and, when stepped, takes on the exclusive-OR of their states. A wide challenge word sets the starting state of every node at once. Every clock-enabled step after that moves the whole state vector forward by one generation. The full state vector and a count of the steps taken are visible at all times.

The wiring is a directed circulant graph with three distinct non-zero offsets. Node `i` reads nodes `(i+OFF_A) mod N`, `(i+OFF_B) mod N` and `(i+OFF_C) mod N`. This makes the graph regular: every node reads exactly three others and feeds exactly three others, and no node reads itself. The table of neighbour indices is computed at elaboration and checked there. A surrounding test or enrolment harness uses the core as follows. It holds the load input high with a challenge present, releases the load input, and then steps the core a chosen number of times. The state vector read at that point is the response.

Top module: `xbn_core`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `state` becomes all zeros and `steps` becomes 0 after that edge.
- R2: When `load` is high at a rising edge (and `rst_n` is high), `state` equals `challenge` and `steps` is 0 after that edge, whatever the value of `step_en`.
- R3: When `load` is low and `step_en` is high at a rising edge, each bit `i` of `state` becomes the XOR of the previous `state` bits at `(i+1) mod 16`, `(i+5) mod 16` and `(i+11) mod 16` (default offsets 1, 5 and 11, with N = 16).
- R4: When `load` and `step_en` are both low, `state` and `steps` keep their values.
- R5: No node reads itself, and every node feeds exactly three nodes. A state with a single bit set at node j therefore steps to exactly three set bits, at `(j-1) mod 16`, `(j-5) mod 16` and `(j-11) mod 16`.
- R6: The all-zero state and the all-one state stay unchanged under any number of steps.
- R7: `steps` rises by one on each step taken while `load` is low, and it saturates at 2^CNT_W-1 (255 by default).
- R8: Changes on `challenge` while `load` is low have no effect on `state` or `steps`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; clears state and step count |
| load | input | 1 | High: every node takes its challenge bit; low: the network may evolve |
| step_en | input | 1 | High: advance the network by one generation this cycle |
| challenge | input | N | Initial state word, one bit per node |
| state | output | N | Current node states, bit i is node i |
| steps | output | CNT_W | Steps taken since load was released, saturating |

## Verification
Every result of this core comes from a register, so the effect of the inputs sampled at one rising edge appears on `state` and `steps` right after that edge. There is no further latency. The driver changes inputs on the falling edge. It computes the expected state and count for the coming rising edge and queues them after that edge. The monitor then compares them on the next falling edge, half a period away from any update. The long saturation run, the one-hot fan-out case and both constant fixed points are checked in the same way. A few extra checks on the fan-out bit pattern and on the final count are made at the same falling-edge point.

// File: rtl/xbn_pkg.sv
// Package: shared constants and index helpers for the XOR Boolean network.
// Assumes: node counts and offsets are positive integers.
package xbn_pkg;

    // Number of inputs each node combines.
    localparam int FANIN = 3;

    // Wrap a node index plus an offset into the range 0..n-1.
    function automatic int wrap_idx(input int base, input int off, input int n);
        return (base + (off % n)) % n;
    endfunction

    // Width needed to hold an index into n nodes (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbn_wiring.sv
// Module: xbn_wiring
// Builds the neighbour index table of the network at elaboration and routes,
// for every node, the states of its three source nodes onto a tap bus.
// Assumes: OFF_A, OFF_B and OFF_C are distinct and none is a multiple of N,
// which gives a 3-regular directed graph without self loops.
module xbn_wiring #(
    parameter int N     = 16,
    parameter int OFF_A = 1,
    parameter int OFF_B = 5,
    parameter int OFF_C = 11
) (
    input  logic [N-1:0]                  node_q,
    output logic [xbn_pkg::FANIN*N-1:0]   taps
);
    import xbn_pkg::*;

    localparam int IDX_W = idx_width(N);
    localparam int TBL_W = FANIN * N * IDX_W;

    // Offset of each input slot.
    localparam int SLOT_OFF [FANIN] = '{OFF_A, OFF_B, OFF_C};

    // Compute the flat neighbour table: entry (node*FANIN+slot) is a source index.
    function automatic logic [TBL_W-1:0] build_table();
        logic [TBL_W-1:0] t;
        t = '0;
        for (int nd = 0; nd < N; nd++) begin
            for (int sl = 0; sl < FANIN; sl++) begin
                t[(nd*FANIN+sl)*IDX_W +: IDX_W] = IDX_W'(wrap_idx(nd, SLOT_OFF[sl], N));
            end
        end
        return t;
    endfunction

    localparam logic [TBL_W-1:0] NB_TABLE = build_table();

    // Reject offset choices that break the regular, loop-free wiring.
    if ((OFF_A % N) == 0 || (OFF_B % N) == 0 || (OFF_C % N) == 0) begin : g_bad_zero
        $error("xbn_wiring: an offset is a multiple of N, a node would read itself");
    end
    if ((OFF_A % N) == (OFF_B % N) || (OFF_A % N) == (OFF_C % N) ||
        (OFF_B % N) == (OFF_C % N)) begin : g_bad_dup
        $error("xbn_wiring: offsets must be distinct modulo N");
    end

    for (genvar nd = 0; nd < N; nd++) begin : g_node
        for (genvar sl = 0; sl < FANIN; sl++) begin : g_slot
            localparam int SRC = int'(NB_TABLE[(nd*FANIN+sl)*IDX_W +: IDX_W]);
            // Elaboration check on each table entry: no self input.
            if (SRC == nd) begin : g_self
                $error("xbn_wiring: node lists itself as an input");
            end
            // Route the source node state onto this tap.
            assign taps[nd*FANIN+sl] = node_q[SRC];
        end
    end

endmodule

// File: rtl/xbn_node.sv
// Module: xbn_node
// One network node: a state flop fed by a mux that picks the challenge bit
// during load, or the XOR of the three neighbour taps on a step.
// Assumes: rst_n is synchronous and active low; load has priority over step_en.
module xbn_node (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       step_en,
    input  logic       seed_bit,
    input  logic [2:0] nb_bits,
    output logic       q
);
    logic mix;

    // Combine the three neighbour states.
    always_comb mix = nb_bits[0] ^ nb_bits[1] ^ nb_bits[2];

    // Update the node state: reset, load the challenge bit, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (load)    q <= seed_bit;
        else if (step_en) q <= mix;
    end

endmodule

// File: rtl/xbn_step_ctr.sv
// Module: xbn_step_ctr
// Counts network steps since load was released, saturating at all ones.
// Assumes: the same load and step_en priority as the nodes.
module xbn_step_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Advance the count on a step, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (load)                       count <= '0;
        else if (step_en && count != CNT_MAX) count <= count + 1'b1;
    end

    // R7
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && count != CNT_MAX) |=> count == $past(count) + 1'b1);

    // R7
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == CNT_MAX) |=> count == CNT_MAX);

endmodule

// File: rtl/xbn_core.sv
// Module: xbn_core (top)
// Synchronous XOR Boolean network of N nodes on a regular circulant graph.
// The challenge sets all nodes while load is high. Each step_en cycle with
// load low advances every node to the XOR of its three source nodes.
// Assumes: default offsets 1, 5, 11 give a valid graph for N = 16.
module xbn_core #(
    parameter int N     = 16,
    parameter int CNT_W = 8,
    parameter int OFF_A = 1,
    parameter int OFF_B = 5,
    parameter int OFF_C = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    input  logic [N-1:0]     challenge,
    output logic [N-1:0]     state,
    output logic [CNT_W-1:0] steps
);
    import xbn_pkg::*;

    logic [N-1:0]       node_q;
    logic [FANIN*N-1:0] taps;

    // Route neighbour states according to the elaborated table.
    xbn_wiring #(
        .N     (N),
        .OFF_A (OFF_A),
        .OFF_B (OFF_B),
        .OFF_C (OFF_C)
    ) u_wiring (
        .node_q (node_q),
        .taps   (taps)
    );

    // One node instance per state bit.
    for (genvar nd = 0; nd < N; nd++) begin : g_nodes
        xbn_node u_node (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .step_en  (step_en),
            .seed_bit (challenge[nd]),
            .nb_bits  (taps[nd*FANIN +: FANIN]),
            .q        (node_q[nd])
        );
    end

    // Count steps since the load was released.
    xbn_step_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step_en (step_en),
        .count   (steps)
    );

    // Drive the state output straight from the node flops.
    always_comb state = node_q;

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state == $past(challenge) && steps == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> ($stable(state) && $stable(steps)));

    // R6
    ones_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && (&state)) |=> (&state));

    // R6
    zeros_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && state == '0) |=> state == '0);

    // R5
    fanout_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step_en && $countones(state) == 1) |=> $countones(state) == FANIN);

endmodule

// File: tb/xbn_core_bench.sv
// Scoreboard bench for xbn_core: the driver queues the expected state and
// count for each edge, and the monitor compares them on the falling edge.
module xbn_core_bench;
    localparam int N     = 16;
    localparam int CNT_W = 8;
    localparam int OA    = 1;
    localparam int OB    = 5;
    localparam int OC    = 11;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic             step_en = 1'b0;
    logic [N-1:0]     challenge = '0;
    logic [N-1:0]     state;
    logic [CNT_W-1:0] steps;

    typedef struct {
        logic [N-1:0] st;
        int           cnt;
        string        req;
    } exp_t;

    exp_t         sb [$];
    int           checks = 0;
    int           errors = 0;
    logic [N-1:0] m_st = '0;
    int           m_cnt = 0;

    xbn_core #(.N(N), .CNT_W(CNT_W), .OFF_A(OA), .OFF_B(OB), .OFF_C(OC)) u_xbn_core (
        .clk (clk), .rst_n (rst_n), .load (load), .step_en (step_en),
        .challenge (challenge), .state (state), .steps (steps)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    // Reference next state from R3.
    function automatic logic [N-1:0] advance(input logic [N-1:0] s);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = s[(i+OA)%N] ^ s[(i+OB)%N] ^ s[(i+OC)%N];
        return r;
    endfunction

    // Drive one cycle, update the model and queue the expected outcome.
    task automatic drive(input logic r, input logic h, input logic e,
                         input logic [N-1:0] c, input string req);
        @(negedge clk);
        rst_n = r; load = h; step_en = e; challenge = c;
        if (!r)     begin m_st = '0; m_cnt = 0; end
        else if (h) begin m_st = c;  m_cnt = 0; end
        else if (e) begin m_st = advance(m_st); if (m_cnt < SAT) m_cnt++; end
        @(posedge clk);
        #1;
        sb.push_back('{st: m_st, cnt: m_cnt, req: req});
    endtask

    // Direct check at the falling edge.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare one expected item per falling edge.
    always @(negedge clk) begin
        exp_t x;
        if (sb.size() > 0) begin
            x = sb.pop_front();
            checks++;
            if (state !== x.st || int'(steps) != x.cnt) begin
                errors++;
                $display("FAIL %s actual state=%h steps=%0d expected state=%h steps=%0d",
                         x.req, state, steps, x.st, x.cnt);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, '0, "R1 reset");
        drive(1'b1, 1'b1, 1'b0, 16'hA5C3, "R2 load");
        for (int k = 0; k < 12; k++) drive(1'b1, 1'b0, 1'b1, 16'hA5C3, "R3 step");
        // R4 idle with a moving challenge, also R8
        drive(1'b1, 1'b0, 1'b0, 16'h1234, "R4 idle");
        drive(1'b1, 1'b0, 1'b0, 16'hFFFF, "R8 challenge ignored");
        drive(1'b1, 1'b0, 1'b1, 16'h0F0F, "R8 step after challenge change");
        drive(1'b1, 1'b1, 1'b1, 16'h3C96, "R2 load beats step_en");
        for (int k = 0; k < 5; k++) drive(1'b1, 1'b0, 1'b1, 16'h0000, "R3 step second pattern");
        drive(1'b0, 1'b0, 1'b1, 16'hFFFF, "R1 reset from busy state");
        // R5 one-hot fan-out
        drive(1'b1, 1'b1, 1'b0, 16'h0001, "R5 load one-hot");
        drive(1'b1, 1'b0, 1'b1, 16'h0001, "R5 one-hot step");
        @(negedge clk); #1;
        check($countones(state) == 3, "R5 fan-out count", $countones(state), 3);
        check(state == 16'h8820, "R5 fan-out targets", int'(state), 32'h8820);
        // R6 fixed points
        drive(1'b1, 1'b1, 1'b0, 16'hFFFF, "R6 load ones");
        for (int k = 0; k < 6; k++) drive(1'b1, 1'b0, 1'b1, 16'h0000, "R6 ones fixed");
        drive(1'b1, 1'b1, 1'b0, 16'h0000, "R6 load zeros");
        for (int k = 0; k < 6; k++) drive(1'b1, 1'b0, 1'b1, 16'hFFFF, "R6 zeros fixed");
        // R7 saturation
        drive(1'b1, 1'b1, 1'b0, 16'h6B2D, "R7 load");
        for (int k = 0; k < SAT + 6; k++) drive(1'b1, 1'b0, 1'b1, 16'h6B2D, "R7 count");
        @(negedge clk); #1;
        check(int'(steps) == SAT, "R7 saturated count", int'(steps), SAT);
        drive(1'b1, 1'b1, 1'b0, 16'h6B2D, "R7 load clears count");
        @(negedge clk); #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule